// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Programmable Read Latency

This block sits on the memory side of a synchronous DRAM data path. It keeps a programmable mode word and turns each registered READ or WRITE command into a run of per-cycle column addresses. For writes it also emits a write strobe on every beat. For reads it produces an output-drive enable and a read-data-valid strobe, both timed by the programmed read latency.

The mode word sets three things: the burst length (1, 2, 4 or 8 beats), the read latency (2 or 3 clocks), and whether writes burst or touch only one location. Column addresses step sequentially and wrap inside an aligned block the size of the burst. A new command issued during a burst cuts the running burst short. A mode load that breaks the encoding rules is refused and raises an error flag.

The mode word can be written only while the block is quiet. The array behind the block, refresh, and bank and row handling are outside this block.

Top module: `sdram_burst_seq`

## Requirements
- R1: Read latency comes from mode bits 6:4. Code 010 selects 2 clocks and code 011 selects 3 clocks. Any other code makes the load illegal.
- R2: For a READ registered at edge n with latency m, rd_vld_o is high in the cycle after edge n+m+k for every beat k of the burst that was not cut off.
- R3: dq_oe_o goes high at edge n+m-1, one cycle before the first valid beat. It stays high across contiguous read beats and drops at the edge after the last beat, in the same cycle that rd_vld_o drops.
- R4: Burst length comes from mode bits 2:0. Codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. With bit 9 clear, this length applies to READs and WRITEs, and wr_o is high on every write beat.
- R5: With mode bit 9 set, each WRITE produces exactly one beat, while READs still use the full programmed length.
- R6: Beat k of a command registered at edge n is shown after edge n+k, with acc_o high and col_o set to the start column with its low log2(length) bits incremented by k modulo the length. The upper bits do not change.
- R7: Mode bits 8:7 must both be zero. Any other value makes the load illegal.
- R8: An accepted illegal load leaves the mode unchanged and sets mode_err_o at the next edge. An accepted legal load applies the word and clears mode_err_o.
- R9: A load is taken only when no burst is active, no read beat is still in flight, and cmd_i is not a command. Otherwise it is ignored, and both the mode and mode_err_o stay unchanged.
- R10: cmd_i encodes 00 as no-op, 01 as READ, 10 as WRITE and 11 as no-op. A READ or WRITE registered while a burst is active ends the old burst at that edge and starts the new one in its place.
- R11: After reset every output is low, and the mode is 1-beat bursts, latency 2, with bursting writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 00 no-op, 01 READ, 10 WRITE, 11 no-op |
| col_i | input | COL_W | Start column sampled with the command |
| mode_ld_i | input | 1 | Request to load the mode word |
| mode_i | input | MODE_W | Mode word (bits 9:0 used) |
| col_o | output | COL_W | Column of the current beat |
| acc_o | output | 1 | A beat is active this cycle |
| wr_o | output | 1 | Active beat is a write |
| dq_oe_o | output | 1 | Data output drive enable |
| rd_vld_o | output | 1 | Read data valid |
| mode_err_o | output | 1 | Last accepted mode load was illegal |

## Verification
The assertions check these relations on every cycle:
- rd_vld_o is always covered by dq_oe_o, and the drive rises before the first valid beat and falls right after the last one.
- The upper column bits stay fixed within a burst.
- Single-location writes never go past their first beat.
- Each accepted load sets or clears the error flag according to whether the word was legal, and a refused load leaves the flag alone.

The exact cycle in which data becomes valid for each latency, the wrap order within each burst length, the point at which truncation cuts a burst, and the fact that a rejected word does not change later timing can be seen only by comparing against the bench's reference model across its scenarios.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  localparam int BEAT_W = 3;   // up to 8 beats
  localparam int ADDR_W = 16;  // internal width for column arithmetic

  // legality of a mode word: burst code, latency code, operating mode
  function automatic logic mode_legal(input logic [9:0] w);
    logic bl_ok, cl_ok, op_ok;
    bl_ok = (w[2] == 1'b0);
    cl_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
    op_ok = (w[8:7] == 2'b00);
    return bl_ok && cl_ok && op_ok;
  endfunction

  // sequential wrap of beat k inside a block of 2**lg columns
  function automatic logic [ADDR_W-1:0] wrap_col(input logic [ADDR_W-1:0] base,
                                                 input logic [BEAT_W-1:0] k,
                                                 input logic [1:0] lg);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << lg) - ADDR_W'(1);
    return (base & ~mask) | ((base + ADDR_W'(k)) & mask);
  endfunction
endpackage

// File: rtl/sdseq_mode_reg.sv
module sdseq_mode_reg #(
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [MODE_W-1:0] word_i,
  input  logic              may_load_i,
  output logic [1:0]        bl_lg_o,
  output logic              cl3_o,
  output logic              wr_single_o,
  output logic              err_o,
  output logic              accept_o,
  output logic              reject_o
);
  import sdseq_pkg::*;

  logic attempt, legal;

  assign attempt  = ld_i && may_load_i;
  assign legal    = mode_legal(word_i[9:0]);
  assign accept_o = attempt && legal;
  assign reject_o = attempt && !legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_lg_o     <= 2'd0;
      cl3_o       <= 1'b0;
      wr_single_o <= 1'b0;
      err_o       <= 1'b0;
    end else if (accept_o) begin
      bl_lg_o     <= word_i[1:0];
      cl3_o       <= word_i[4];
      wr_single_o <= word_i[9];
      err_o       <= 1'b0;
    end else if (reject_o) begin
      err_o       <= 1'b1;
    end
  end
endmodule

// File: rtl/sdseq_burst_engine.sv
module sdseq_burst_engine #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       bl_lg_i,
  input  logic             wr_single_i,
  output logic             active_o,
  output logic             wr_o,
  output logic             rd_beat_o,
  output logic [COL_W-1:0] col_o,
  output logic             first_o,
  output logic             last_o
);
  import sdseq_pkg::*;

  logic                  is_wr_q;
  logic [COL_W-1:0]      base_q;
  logic [BEAT_W-1:0]     k_q;
  logic [1:0]            lg_q;
  logic [BEAT_W-1:0]     last_k;
  logic [ADDR_W-1:0]     wide_col;

  assign last_k    = BEAT_W'((4'd1 << lg_q) - 4'd1);
  assign last_o    = active_o && (k_q == last_k);
  assign first_o   = active_o && (k_q == '0);
  assign wr_o      = active_o && is_wr_q;
  assign rd_beat_o = active_o && !is_wr_q;
  assign wide_col  = wrap_col(ADDR_W'(base_q), k_q, lg_q);
  assign col_o     = wide_col[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      is_wr_q  <= 1'b0;
      base_q   <= '0;
      k_q      <= '0;
      lg_q     <= 2'd0;
    end else if (start_i) begin
      active_o <= 1'b1;
      is_wr_q  <= is_wr_i;
      base_q   <= col_i;
      k_q      <= '0;
      lg_q     <= (is_wr_i && wr_single_i) ? 2'd0 : bl_lg_i;
    end else if (active_o) begin
      if (last_o) active_o <= 1'b0;
      else        k_q      <= k_q + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/sdseq_rd_pipe.sv
module sdseq_rd_pipe #(
  parameter int MAX_CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_i,
  input  logic cl3_i,
  output logic vld_o,
  output logic oe_o,
  output logic busy_o
);
  logic [MAX_CL:1] pipe_q;
  int cl;

  always_comb begin
    cl     = cl3_i ? 3 : 2;
    vld_o  = pipe_q[cl];
    oe_o   = pipe_q[cl] | pipe_q[cl-1];
    busy_o = 1'b0;
    for (int j = 1; j <= MAX_CL; j++)
      if (j <= cl) busy_o = busy_o | pipe_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[MAX_CL-1:1], beat_i};
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W  = 10,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              mode_ld_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [COL_W-1:0]  col_o,
  output logic              acc_o,
  output logic              wr_o,
  output logic              dq_oe_o,
  output logic              rd_vld_o,
  output logic              mode_err_o
);
  import sdseq_pkg::*;

  // named internal events
  logic       burst_start, is_wr_cmd, may_load, idle_w;
  logic       mode_accept, mode_reject;
  logic       beat_first, beat_last, rd_beat, pipe_busy;
  logic [1:0] bl_lg;
  logic       cl3, wr_single;

  assign is_wr_cmd   = (cmd_i == CMD_WR);
  assign burst_start = (cmd_i == CMD_RD) || is_wr_cmd;
  assign idle_w      = !acc_o && !pipe_busy;
  assign may_load    = idle_w && !burst_start;

  sdseq_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .ld_i(mode_ld_i), .word_i(mode_i),
    .may_load_i(may_load), .bl_lg_o(bl_lg), .cl3_o(cl3),
    .wr_single_o(wr_single), .err_o(mode_err_o),
    .accept_o(mode_accept), .reject_o(mode_reject)
  );

  sdseq_burst_engine #(.COL_W(COL_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(burst_start), .is_wr_i(is_wr_cmd),
    .col_i(col_i), .bl_lg_i(bl_lg), .wr_single_i(wr_single),
    .active_o(acc_o), .wr_o(wr_o), .rd_beat_o(rd_beat), .col_o(col_o),
    .first_o(beat_first), .last_o(beat_last)
  );

  sdseq_rd_pipe #(.MAX_CL(3)) u_pipe (
    .clk(clk), .rst_n(rst_n), .beat_i(rd_beat), .cl3_i(cl3),
    .vld_o(rd_vld_o), .oe_o(dq_oe_o), .busy_o(pipe_busy)
  );
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COL_W-1:0] col_o,
  input logic             acc_o,
  input logic             wr_o,
  input logic             dq_oe_o,
  input logic             rd_vld_o,
  input logic             mode_err_o,
  input logic             mode_ld_i,
  input logic             burst_start,
  input logic             idle_w,
  input logic             mode_accept,
  input logic             mode_reject,
  input logic             beat_first,
  input logic             beat_last,
  input logic             wr_single
);
  // R3
  vld_under_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> dq_oe_o);
  // R3
  oe_leads_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_vld_o) |-> $past(dq_oe_o));
  // R3
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe_o) |-> $past(rd_vld_o));
  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && wr_single) |-> beat_first);
  // R6
  col_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o && !beat_last && !burst_start) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));
  // R8
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reject |=> mode_err_o);
  // R8
  accept_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_accept |=> !mode_err_o);
  // R9
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ld_i && (!idle_w || burst_start)) |=> $stable(mode_err_o));
endmodule

bind sdram_burst_seq sdseq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .col_o(col_o), .acc_o(acc_o), .wr_o(wr_o),
  .dq_oe_o(dq_oe_o), .rd_vld_o(rd_vld_o), .mode_err_o(mode_err_o),
  .mode_ld_i(mode_ld_i), .burst_start(burst_start), .idle_w(idle_w),
  .mode_accept(mode_accept), .mode_reject(mode_reject),
  .beat_first(beat_first), .beat_last(beat_last), .wr_single(wr_single)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [COL_W-1:0] col = '0;
  logic ld = 1'b0;
  logic [9:0] mw = '0;
  logic [COL_W-1:0] col_o;
  logic acc_o, wr_o, dq_oe_o, rd_vld_o, mode_err_o;

  always #4 clk = ~clk;  // 125 MHz

  sdram_burst_seq #(.COL_W(COL_W), .MODE_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col), .mode_ld_i(ld),
    .mode_i(mw), .col_o(col_o), .acc_o(acc_o), .wr_o(wr_o),
    .dq_oe_o(dq_oe_o), .rd_vld_o(rd_vld_o), .mode_err_o(mode_err_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model: expectations per cycle, circular by 64
  bit e_acc[64], e_wr[64], e_rv[64];
  int e_col[64];
  int cyc = 0;
  int m_len = 1, m_lat = 2;
  bit m_single = 0, m_err = 0;

  function automatic int s(input int c); return c & 63; endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic model_edge();
    bit idle;
    cyc++;
    e_acc[s(cyc+30)] = 0; e_wr[s(cyc+30)] = 0; e_rv[s(cyc+30)] = 0;
    idle = !e_acc[s(cyc-1)];
    for (int c = cyc - 1; c <= cyc + m_lat - 2; c++) if (e_rv[s(c)]) idle = 0;
    if (cmd == 2'b01 || cmd == 2'b10) begin
      // R10: cut the running burst at this edge
      for (int c = cyc; c < cyc + 8; c++) begin
        if (e_acc[s(c)] && !e_wr[s(c)]) e_rv[s(c + m_lat)] = 0;
        e_acc[s(c)] = 0; e_wr[s(c)] = 0;
      end
      begin
        int len;
        bit w;
        w = (cmd == 2'b10);
        len = (w && m_single) ? 1 : m_len;
        for (int k = 0; k < len; k++) begin
          e_acc[s(cyc+k)] = 1;
          e_wr[s(cyc+k)]  = w;
          e_col[s(cyc+k)] = (int'(col) / len) * len + ((int'(col) + k) % len);
          if (!w) e_rv[s(cyc+k+m_lat)] = 1;
        end
      end
    end else if (ld && idle) begin
      if (mw[2] == 0 && (mw[6:4] == 3'b010 || mw[6:4] == 3'b011) && mw[8:7] == 0) begin
        m_len = 1 << mw[1:0];
        m_lat = (mw[6:4] == 3'b011) ? 3 : 2;
        m_single = mw[9];
        m_err = 0;
      end else m_err = 1;
    end
  endtask

  task automatic compare();
    chk("R6 acc", acc_o, e_acc[s(cyc)]);
    if (e_acc[s(cyc)]) chk("R6 col", col_o, e_col[s(cyc)]);
    chk("R4/R5 wr", wr_o, e_wr[s(cyc)]);
    chk("R2 rd_vld", rd_vld_o, e_rv[s(cyc)]);
    chk("R3 oe", dq_oe_o, e_rv[s(cyc)] | e_rv[s(cyc+1)]);
    chk("R8 err", mode_err_o, m_err);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic issue(input logic [1:0] c, input int a);
    cmd = c; col = COL_W'(a);
    step();
    cmd = 2'b00;
  endtask

  task automatic load(input logic [9:0] w);
    ld = 1; mw = w;
    step();
    ld = 0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 reset outputs", {col_o != 0, acc_o, wr_o, dq_oe_o, rd_vld_o, mode_err_o}, 0);
    rst_n = 1;
    gap(2);
    // R11/R2/R3: default 1 beat, latency 2
    issue(2'b01, 'h05); gap(6);
    // R4/R6/R1: 4 beats latency 2, wrap from 0x0D
    load(10'h022); gap(2);
    issue(2'b01, 'h0D); gap(8);
    issue(2'b10, 'h0E); gap(6);
    // R1/R4: 8 beats latency 3
    load(10'h033); gap(2);
    issue(2'b01, 'h15); gap(14);
    issue(2'b10, 'h1A); gap(10);
    // R4: 2 beats
    load(10'h031); gap(2);
    issue(2'b01, 'h2B); gap(7);
    // R5: single-location writes, reads still burst
    load(10'h222); gap(2);
    issue(2'b10, 'h33); gap(3);
    issue(2'b01, 'h33); gap(8);
    // R8/R1: illegal latency code, mode kept
    load(10'h012); gap(2);
    issue(2'b01, 'h40); gap(8);
    // R7: reserved operating mode bits
    load(10'h0A2); gap(2);
    load(10'h133); gap(2);
    // R8: illegal burst code
    load(10'h024); gap(2);
    load(10'h022); gap(2);
    // R9: load during a burst and during the read tail, and with a command
    issue(2'b01, 'h50); load(10'h033); gap(2); load(10'h031); gap(8);
    cmd = 2'b01; col = 'h60; ld = 1; mw = 10'h012; step(); cmd = 2'b00; ld = 0; gap(8);
    // R10: truncation, read by read and read by write, back-to-back
    issue(2'b01, 'h70); gap(1); issue(2'b01, 'h7C); gap(8);
    issue(2'b01, 'h80); issue(2'b10, 'h90); gap(8);
    issue(2'b01, 'hA0); gap(3); issue(2'b01, 'hA4); gap(8);
    load(10'h033); gap(2);
    issue(2'b01, 'hB3); gap(2); issue(2'b10, 'hC0); gap(12);
    // R10: code 11 is a no-op
    issue(2'b11, 'hD0); gap(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule